// File: doc/BRIEF.md
# Handshaked Processor Bus Cycle Unit

This block sits between a processor core and an external memory bus whose cycle length is set by the memory. The core raises one request line together with a read/write qualifier, an address and write data. The unit latches these values and runs a single bus cycle. It asserts an active-low address strobe for one clock while the latched address and the direction line are on the bus. It then waits until the memory pulls an active-low ready input low.

Read data is taken from the bus on the clock edge where ready is seen low. On that same edge the unit gives the core a one-clock done pulse. For a write, the data drivers are enabled from the first bus clock until the cycle ends. The memory can insert any number of wait states by holding ready high.

Top module: `bus_cycle_unit`

## Requirements
- R1: When `core_req` is high and `core_wr` is 1 at a rising edge in idle, on that edge `bus_strobe_n` goes low, `bus_addr` takes `core_addr`, `bus_wr` goes to 1 and `bus_wdata` takes `core_wdata`.
- R2: When `core_req` is high and `core_wr` is 0 at a rising edge in idle, on that edge a read cycle starts with `bus_strobe_n` low and `bus_wr` at 0, and `bus_wdata_oe` stays 0.
- R3: `bus_strobe_n` is low for exactly one clock per bus cycle.
- R4: `bus_ready_n` is ignored in the first bus clock and is sampled in every later clock of the cycle. `core_done` rises on the edge that is 2+N rising edges after acceptance, where N is the number of wait edges on which ready was high. With one wait state the cycle therefore lasts three bus clocks.
- R5: On a read, `core_rdata` takes the value of `bus_rdata` sampled on the edge where ready is low. It then keeps that value through later write cycles until the next read completes.
- R6: `core_done` is high for exactly one clock per bus cycle.
- R7: On a write, `bus_wdata_oe` is 1 from the first bus clock until the edge that ends the cycle, when it returns to 0. In idle and during reads it is 0, and `bus_wr` returns to 0 when the cycle ends.
- R8: A change of `core_req`, `core_wr` or `core_addr` during a cycle is ignored, so `bus_addr` is unchanged. If `core_req` is still high in the clock after done, a new cycle starts on the next edge.
- R9: While `rst` is high at a rising edge, the unit goes to idle with `bus_strobe_n` at 1, `bus_wdata_oe` at 0 and `core_done` at 0. This applies mid-cycle too, and a later ready low produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| core_req | input | 1 | Core requests a bus cycle |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Address from the core |
| core_wdata | input | DATA_W | Write data from the core |
| core_rdata | output | DATA_W | Captured read data |
| core_done | output | 1 | One-clock cycle completion pulse |
| bus_addr | output | ADDR_W | Address on the bus |
| bus_strobe_n | output | 1 | Address strobe, active low |
| bus_wr | output | 1 | Direction, 1 = write |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_wdata_oe | output | 1 | Write data driver enable |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_ready_n | input | 1 | Memory ready, active low |

## Verification
Strobe, address, direction and driver enable are due one rising edge after the request is accepted. The strobe is back high after the second edge. Done and the captured read data are due 2+N edges after acceptance, where N counts the ready-high edges in the wait phase.

The bench drives inputs and samples outputs on falling edges, so every check looks at the result of exactly one counted rising edge. It checks at each intermediate edge that done is still low. The directed tests hold ready low from the start, change the request mid-cycle and reset mid-cycle, and then check the same edge counts.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2
    } bcu_state_e;
endpackage

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
    import bcu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ready_n,
    output logic load,
    output logic finish,
    output logic strobe_n,
    output logic done
);
    typedef struct packed {
        bcu_state_e state;
        logic       strobe_n;
        logic       done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d          = c_q;
        c_d.strobe_n = 1'b1;
        c_d.done     = 1'b0;
        load         = 1'b0;
        finish       = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (req) begin
                    load         = 1'b1;
                    c_d.state    = ST_ADDR;
                    c_d.strobe_n = 1'b0;
                end
            end
            ST_ADDR: begin
                c_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (!ready_n) begin
                    finish    = 1'b1;
                    c_d.done  = 1'b1;
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.state    <= ST_IDLE;
            c_q.strobe_n <= 1'b1;
            c_q.done     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign strobe_n = c_q.strobe_n;
    assign done     = c_q.done;
endmodule

// File: rtl/bcu_dpath.sv
module bcu_dpath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              finish,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              wr,
    output logic [DATA_W-1:0] wdata,
    output logic              wdata_oe,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              oe;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (load) begin
            p_d.addr  = in_addr;
            p_d.wr    = in_wr;
            p_d.wdata = in_wdata;
            p_d.oe    = in_wr;
        end else if (finish) begin
            p_d.oe = 1'b0;
            p_d.wr = 1'b0;
            if (!p_q.wr) begin
                p_d.rdata = bus_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign addr     = p_q.addr;
    assign wr       = p_q.wr;
    assign wdata    = p_q.wdata;
    assign wdata_oe = p_q.oe;
    assign rdata    = p_q.rdata;
endmodule

// File: rtl/bus_cycle_unit.sv
module bus_cycle_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic              core_wr,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_strobe_n,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready_n
);
    logic load, finish;

    bcu_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .req      (core_req),
        .ready_n  (bus_ready_n),
        .load     (load),
        .finish   (finish),
        .strobe_n (bus_strobe_n),
        .done     (core_done)
    );

    bcu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .finish    (finish),
        .in_wr     (core_wr),
        .in_addr   (core_addr),
        .in_wdata  (core_wdata),
        .bus_rdata (bus_rdata),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .wdata_oe  (bus_wdata_oe),
        .rdata     (core_rdata)
    );
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] core_rdata,
    input logic              core_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_strobe_n,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wdata_oe,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready_n
);
    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe_n |=> bus_strobe_n); // R3

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        core_done |=> !core_done); // R6

    AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        core_done |-> $past(!bus_ready_n)); // R4

    AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_wdata_oe |-> bus_wr); // R7

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_wdata_oe && $past(bus_wdata_oe)) |-> ($stable(bus_addr) && $stable(bus_wdata))); // R8

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (core_done && !$past(bus_wr)) |-> (core_rdata == $past(bus_rdata))); // R5
endmodule

bind bus_cycle_unit bcu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .core_rdata   (core_rdata),
    .core_done    (core_done),
    .bus_addr     (bus_addr),
    .bus_strobe_n (bus_strobe_n),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_rdata    (bus_rdata),
    .bus_ready_n  (bus_ready_n)
);

// File: tb/bus_cycle_unit_tb.sv
module bus_cycle_unit_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          core_req = 1'b0;
    logic          core_wr = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;
    logic          core_done;
    logic [AW-1:0] bus_addr;
    logic          bus_strobe_n;
    logic          bus_wr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wdata_oe;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready_n = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    bus_cycle_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .core_req(core_req), .core_wr(core_wr),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .core_done(core_done), .bus_addr(bus_addr), .bus_strobe_n(bus_strobe_n),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata(bus_rdata), .bus_ready_n(bus_ready_n)
    );

    // {wr, addr, wdata, wait edges, memory read value}
    localparam int VW = 1 + AW + DW + 4 + DW;
    localparam logic [VW-1:0] VEC [6] = '{
        {1'b1, 16'h1234, 8'hA5, 4'd0, 8'h00},
        {1'b0, 16'h00F0, 8'h00, 4'd1, 8'h3C},
        {1'b1, 16'hBEEF, 8'h5A, 4'd3, 8'hFF},
        {1'b0, 16'hFFFF, 8'hFF, 4'd0, 8'hC3},
        {1'b0, 16'h0001, 8'h11, 4'd5, 8'h81},
        {1'b1, 16'h8000, 8'h00, 4'd2, 8'h77}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input int waits, input logic [DW-1:0] rd);
        @(negedge clk);
        core_req = 1'b1; core_wr = wr; core_addr = a; core_wdata = wd; bus_ready_n = 1'b1;
        @(negedge clk);
        core_req = 1'b0;
        chk(bus_strobe_n == 1'b0, "R1/R2 strobe low", 32'(bus_strobe_n), 0);
        chk(bus_addr == a, "R1 address", 32'(bus_addr), 32'(a));
        chk(bus_wr == wr, "R1/R2 direction", 32'(bus_wr), 32'(wr));
        chk(bus_wdata_oe == wr, "R7 enable at start", 32'(bus_wdata_oe), 32'(wr));
        if (wr) chk(bus_wdata == wd, "R1 write data", 32'(bus_wdata), 32'(wd));
        @(negedge clk);
        chk(bus_strobe_n == 1'b1, "R3 strobe one clock", 32'(bus_strobe_n), 1);
        chk(core_done == 1'b0, "R4 no done in first wait", 32'(core_done), 0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk(core_done == 1'b0, "R4 wait state", 32'(core_done), 0);
            chk(bus_wdata_oe == wr, "R7 enable held", 32'(bus_wdata_oe), 32'(wr));
        end
        bus_ready_n = 1'b0; bus_rdata = rd;
        @(negedge clk);
        bus_ready_n = 1'b1;
        if (!wr) last_rd = rd;
        chk(core_done == 1'b1, "R4 done after 2+N edges", 32'(core_done), 1);
        chk(core_rdata == last_rd, "R5 read data", 32'(core_rdata), 32'(last_rd));
        chk(bus_wdata_oe == 1'b0, "R7 enable off at end", 32'(bus_wdata_oe), 0);
        chk(bus_wr == 1'b0, "R7 direction back to read", 32'(bus_wr), 0);
        @(negedge clk);
        chk(core_done == 1'b0, "R6 done one clock", 32'(core_done), 0);
        chk(bus_strobe_n == 1'b1, "R8 no new cycle", 32'(bus_strobe_n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(bus_strobe_n == 1'b1, "R9 reset strobe", 32'(bus_strobe_n), 1);
        chk(bus_wdata_oe == 1'b0, "R9 reset enable", 32'(bus_wdata_oe), 0);
        chk(core_done == 1'b0, "R9 reset done", 32'(core_done), 0);
        rst = 1'b0;

        for (int v = 0; v < 6; v++) begin
            run_cycle(VEC[v][VW-1], VEC[v][VW-2 -: AW], VEC[v][4+DW+DW-1 -: DW],
                      int'(VEC[v][DW+3 -: 4]), VEC[v][DW-1:0]);
        end

        // R4: ready held low from the start; first clock ignores it
        @(negedge clk);
        bus_ready_n = 1'b0; bus_rdata = 8'h42;
        core_req = 1'b1; core_wr = 1'b0; core_addr = 16'h0404;
        @(negedge clk);
        core_req = 1'b0;
        chk(core_done == 1'b0, "R4 ready ignored in first clock", 32'(core_done), 0);
        @(negedge clk);
        chk(core_done == 1'b0, "R4 ready ignored in first clock", 32'(core_done), 0);
        @(negedge clk);
        last_rd = 8'h42;
        chk(core_done == 1'b1, "R4 zero wait done", 32'(core_done), 1);
        chk(core_rdata == 8'h42, "R5 zero wait data", 32'(core_rdata), 32'h42);
        bus_ready_n = 1'b1;

        // R8: mid-cycle changes ignored, request held restarts
        @(negedge clk);
        core_req = 1'b1; core_wr = 1'b1; core_addr = 16'h0A0A; core_wdata = 8'h99;
        @(negedge clk);
        core_wr = 1'b0; core_addr = 16'h0B0B;
        @(negedge clk);
        chk(bus_addr == 16'h0A0A, "R8 address held", 32'(bus_addr), 32'h0A0A);
        chk(bus_wr == 1'b1, "R8 direction held", 32'(bus_wr), 1);
        bus_ready_n = 1'b0;
        @(negedge clk);
        bus_ready_n = 1'b1;
        chk(core_done == 1'b1, "R8 first cycle done", 32'(core_done), 1);
        chk(core_rdata == last_rd, "R5 write keeps read data", 32'(core_rdata), 32'(last_rd));
        @(negedge clk);
        chk(bus_strobe_n == 1'b0, "R8 back-to-back start", 32'(bus_strobe_n), 0);
        chk(bus_addr == 16'h0B0B, "R8 new address", 32'(bus_addr), 32'h0B0B);
        core_req = 1'b0;
        @(negedge clk);
        bus_ready_n = 1'b0; bus_rdata = 8'h6E;
        @(negedge clk);
        bus_ready_n = 1'b1;
        last_rd = 8'h6E;
        chk(core_done == 1'b1, "R8 second cycle done", 32'(core_done), 1);

        // R9: reset mid write cycle
        @(negedge clk);
        core_req = 1'b1; core_wr = 1'b1; core_addr = 16'h0C0C; core_wdata = 8'h12;
        @(negedge clk);
        core_req = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(bus_strobe_n == 1'b1, "R9 mid-cycle strobe", 32'(bus_strobe_n), 1);
        chk(bus_wdata_oe == 1'b0, "R9 mid-cycle enable", 32'(bus_wdata_oe), 0);
        rst = 1'b0;
        bus_ready_n = 1'b0;
        @(negedge clk);
        chk(core_done == 1'b0, "R9 no done after reset", 32'(core_done), 0);
        @(negedge clk);
        chk(core_done == 1'b0, "R9 no done after reset", 32'(core_done), 0);
        bus_ready_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule